// File: doc/BRIEF.md
# Comparator Edge-Select Interrupt Controller

This block is the digital side of an on-chip voltage comparator. The comparator's result bit is asynchronous to the system clock. The block passes that bit through a two-stage synchronizer. It then compares the synchronized value with its value one cycle earlier to find rising and falling transitions. When a transition matches the selected event mode, a sticky interrupt flag is set.

Software reaches a single 8-bit control/status register through a simple address/write-enable bus. The read path is combinational. The register holds:

- a power-down bit for the comparator,
- the live synchronized comparator value,
- the flag,
- a local interrupt enable,
- a two-bit event mode.

An interrupt request leaves the block when the flag, the local enable and a global enable input are all high. The interrupt controller's acknowledge pulse clears the flag, and so does a software write of one to the flag bit.

Switching the comparator off forces the live value low. That forced transition is treated like any other transition, so it can raise the flag. Software should therefore clear the local enable before changing the power-down bit.

Top module: `cmp_edge_irq`

## Requirements
- R1: The live bit (bit 5) follows the comparator input two clock edges after the input changes, while the block is powered up. The comparator result is 1 when the positive input is above the negative input.
- R2: Mode `11` (bits 1:0) sets the flag (bit 4) on a 0-to-1 transition of the live value only.
- R3: Mode `10` sets the flag on a 1-to-0 transition of the live value only.
- R4: Mode `00` sets the flag on any transition of the live value.
- R5: Mode `01` never sets the flag.
- R6: `irqReq` is high exactly when the flag, the enable bit (bit 3) and `globalIrqEn` are all high.
- R7: A one-cycle `irqAck` pulse clears the flag.
- R8: A register write with bit 4 set clears the flag, and a write with bit 4 clear leaves it unchanged.
- R9: When a flag-setting event and a clear (acknowledge or write-one) fall in the same cycle, the flag ends up set.
- R10: While the power-down bit (bit 7) is 1, the live bit reads 0 and `cmpPowerDown` is 1. The transitions caused by powering down or powering up are treated as ordinary events: powering down with the input high is a falling transition, and powering up with the input high is a rising transition.
- R11: The register answers only at address 0x08; other addresses read 0 and ignore writes. Bits 6 and 2 always read 0. After reset all writable bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawCmp | input | 1 | Asynchronous comparator result |
| busAddr | input | 6 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from the address |
| globalIrqEn | input | 1 | Global interrupt enable |
| irqAck | input | 1 | Acknowledge pulse from the interrupt controller |
| irqReq | output | 1 | Interrupt request |
| cmpPowerDown | output | 1 | Powers the analog comparator off |

## Verification
Faults in the stored state show at the ports quickly:

- A stale previous-value register or a wrong mode decode shows as a wrong flag bit. It appears on the third clock edge after the input changes: two synchronizer edges plus the flag register.
- A wrong flag-update priority shows the cycle after an acknowledge that coincides with an event.
- A power-down gate that does not force the live value low shows at once, both in bit 5 and in the flag one edge later.

Each case is sampled on the falling clock edge after the edge on which the change lands.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_NONE   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } evtMode_e;

  typedef struct packed {
    logic wrCtl;
    logic clrFlag;
    logic setFlag;
  } ctlStrobe_t;

  localparam int REG_W    = 8;
  localparam int DIS_BIT  = 7;
  localparam int LIVE_BIT = 5;
  localparam int FLAG_BIT = 4;
  localparam int IE_BIT   = 3;
endpackage

// File: rtl/cmp_irq_control.sv
module cmp_irq_control
  import cmp_irq_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int REG_ADDR = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              wrFlagBit,
  input  logic              irqAck,
  input  logic              riseEvt,
  input  logic              fallEvt,
  input  evtMode_e          mode,
  output logic              regSel,
  output ctlStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

  logic evtMatch;

  assign regSel = (busAddr == SEL_ADDR);

  always_comb begin
    unique case (mode)
      MODE_TOGGLE: evtMatch = riseEvt | fallEvt;
      MODE_FALL:   evtMatch = fallEvt;
      MODE_RISE:   evtMatch = riseEvt;
      default:     evtMatch = 1'b0;
    endcase
  end

  always_comb begin
    strb.wrCtl   = busWrEn & regSel;
    strb.clrFlag = irqAck | (busWrEn & regSel & wrFlagBit);
    strb.setFlag = evtMatch;
  end
endmodule

// File: rtl/cmp_irq_datapath.sv
module cmp_irq_datapath
  import cmp_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawCmp,
  input  ctlStrobe_t       strb,
  input  logic             wrDis,
  input  logic             wrIe,
  input  logic [1:0]       wrMode,
  input  logic             regSel,
  output logic [REG_W-1:0] rdData,
  output evtMode_e         mode,
  output logic             riseEvt,
  output logic             fallEvt,
  output logic             flagQ,
  output logic             ieQ,
  output logic             disQ,
  output logic             liveOut,
  output logic             prevOut
);
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= rawCmp;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawCmp};
    end
  endgenerate

  assign liveOut = syncQ[SYNC_STAGES-1] & ~disQ;
  assign riseEvt = liveOut & ~prevOut;
  assign fallEvt = ~liveOut & prevOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut <= 1'b0;
      disQ    <= 1'b0;
      ieQ     <= 1'b0;
      mode    <= MODE_TOGGLE;
    end else begin
      prevOut <= liveOut;
      if (strb.wrCtl) begin
        disQ <= wrDis;
        ieQ  <= wrIe;
        mode <= evtMode_e'(wrMode);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flagQ <= 1'b0;
    else if (strb.setFlag)  flagQ <= 1'b1;
    else if (strb.clrFlag)  flagQ <= 1'b0;
  end

  assign rdData = regSel ? {disQ, 1'b0, liveOut, flagQ, ieQ, 1'b0, mode} : '0;
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq
  import cmp_irq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int REG_ADDR    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawCmp,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              globalIrqEn,
  input  logic              irqAck,
  output logic              irqReq,
  output logic              cmpPowerDown
);
  ctlStrobe_t strb;
  evtMode_e   mode;
  logic regSel, riseEvt, fallEvt, flagQ, ieQ, disQ, liveOut, prevOut;
  logic unusedWrBits;

  assign unusedWrBits = ^{busWrData[6:5], busWrData[2]};

  cmp_irq_control #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctl (
    .busAddr(busAddr), .busWrEn(busWrEn), .wrFlagBit(busWrData[FLAG_BIT]),
    .irqAck(irqAck), .riseEvt(riseEvt), .fallEvt(fallEvt), .mode(mode),
    .regSel(regSel), .strb(strb)
  );

  cmp_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .strb(strb),
    .wrDis(busWrData[DIS_BIT]), .wrIe(busWrData[IE_BIT]), .wrMode(busWrData[1:0]),
    .regSel(regSel), .rdData(busRdData), .mode(mode),
    .riseEvt(riseEvt), .fallEvt(fallEvt), .flagQ(flagQ), .ieQ(ieQ),
    .disQ(disQ), .liveOut(liveOut), .prevOut(prevOut)
  );

  assign irqReq       = flagQ & ieQ & globalIrqEn;
  assign cmpPowerDown = disQ;
endmodule

// File: rtl/cmp_edge_irq_chk.sv
module cmp_edge_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       globalIrqEn,
  input logic       irqAck,
  input logic       irqReq,
  input logic       flagQ,
  input logic       ieQ,
  input logic       disQ,
  input logic       liveOut,
  input logic       prevOut,
  input logic [1:0] mode,
  input logic       setFlag,
  input logic [7:0] busRdData
);
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (globalIrqEn && ieQ && flagQ));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !setFlag) |=> !flagQ);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && setFlag) |=> flagQ);

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && liveOut && !prevOut) |=> flagQ);

  a_r10_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
    disQ |-> !liveOut);

  always @(posedge clk)
    if (rstN) a_r11_reserved_zero: assert (busRdData[6] == 1'b0 && busRdData[2] == 1'b0);
endmodule

bind cmp_edge_irq cmp_edge_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .globalIrqEn(globalIrqEn), .irqAck(irqAck),
  .irqReq(irqReq), .flagQ(flagQ), .ieQ(ieQ), .disQ(disQ), .liveOut(liveOut),
  .prevOut(prevOut), .mode(mode), .setFlag(strb.setFlag), .busRdData(busRdData)
);

// File: tb/cmp_edge_irq_tb.sv
`timescale 1ns/1ps
module cmp_edge_irq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawCmp = 1'b0;
  logic [5:0] busAddr = 6'h08;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic globalIrqEn = 1'b0;
  logic irqAck = 1'b0;
  logic irqReq, cmpPowerDown;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_edge_irq u_dut (
    .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .globalIrqEn(globalIrqEn), .irqAck(irqAck), .irqReq(irqReq),
    .cmpPowerDown(cmpPowerDown)
  );

  // {mode[1:0], rawFrom, rawTo, expectedFlag}
  localparam logic [4:0] VEC [12] = '{
    5'b11_01_1, 5'b11_10_0, 5'b11_11_0,
    5'b10_01_0, 5'b10_10_1, 5'b10_11_0,
    5'b00_01_1, 5'b00_10_1, 5'b00_11_0,
    5'b01_01_0, 5'b01_10_0, 5'b01_11_0
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [5:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 6'h08;
  endtask

  task automatic readReg(input logic [5:0] addr, output logic [7:0] data);
    busAddr = addr;
    #1;
    data = busRdData;
    busAddr = 6'h08;
    #1;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b11:   return "R2";
      2'b10:   return "R3";
      2'b00:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R11: reset state
    readReg(6'h08, rd);
    check("R11 reset value", rd, 8'h00);
    check("R6 reset irqReq", {7'b0, irqReq}, 8'h00);
    check("R10 reset powerdown", {7'b0, cmpPowerDown}, 8'h00);

    // R1: two-edge latency of live bit
    @(negedge clk); rawCmp = 1'b1;
    @(negedge clk); readReg(6'h08, rd);
    check("R1 live after one edge", {7'b0, rd[5]}, 8'h00);
    @(negedge clk); readReg(6'h08, rd);
    check("R1 live after two edges", {7'b0, rd[5]}, 8'h01);

    // Table of mode / transition vectors (R2..R5)
    for (int v = 0; v < 12; v++) begin
      logic [1:0] m;
      m = VEC[v][4:3];
      writeReg(6'h08, {6'b0, m});
      rawCmp = VEC[v][2];
      waitCycles(5);
      writeReg(6'h08, {3'b000, 1'b1, 2'b00, m});
      rawCmp = VEC[v][1];
      waitCycles(5);
      readReg(6'h08, rd);
      check(modeTag(m), {7'b0, rd[4]}, {7'b0, VEC[v][0]});
    end

    // R6 / R7 / R8 in rising mode with the enable on
    writeReg(6'h08, 8'h0B);
    rawCmp = 1'b0; waitCycles(5);
    writeReg(6'h08, 8'h1B);
    rawCmp = 1'b1; waitCycles(5);
    globalIrqEn = 1'b0; #1;
    check("R6 global off", {7'b0, irqReq}, 8'h00);
    globalIrqEn = 1'b1; #1;
    check("R6 all on", {7'b0, irqReq}, 8'h01);
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    readReg(6'h08, rd);
    check("R7 ack clears flag", {7'b0, rd[4]}, 8'h00);
    check("R7 irq drops", {7'b0, irqReq}, 8'h00);

    rawCmp = 1'b0; waitCycles(5);
    rawCmp = 1'b1; waitCycles(5);
    writeReg(6'h08, 8'h03);
    check("R6 local enable off", {7'b0, irqReq}, 8'h00);
    writeReg(6'h08, 8'h0B);
    readReg(6'h08, rd);
    check("R8 write zero keeps flag", {7'b0, rd[4]}, 8'h01);
    writeReg(6'h08, 8'h1B);
    readReg(6'h08, rd);
    check("R8 write one clears flag", {7'b0, rd[4]}, 8'h00);

    // R9: acknowledge in the same cycle as a toggle event
    writeReg(6'h08, 8'h00);
    rawCmp = 1'b0; waitCycles(5);
    readReg(6'h08, rd);
    check("R9 flag primed", {7'b0, rd[4]}, 8'h01);
    @(negedge clk); rawCmp = 1'b1;
    @(negedge clk);
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    readReg(6'h08, rd);
    check("R9 set beats ack", {7'b0, rd[4]}, 8'h01);

    // R10: power-down forces live low and its edges count
    writeReg(6'h08, 8'h10);
    writeReg(6'h08, 8'h80);
    waitCycles(2);
    readReg(6'h08, rd);
    check("R10 power-down fall event", rd, 8'h90);
    check("R10 powerdown pin", {7'b0, cmpPowerDown}, 8'h01);
    writeReg(6'h08, 8'h90);
    readReg(6'h08, rd);
    check("R10 cleared while off", rd, 8'h80);
    writeReg(6'h08, 8'h00);
    waitCycles(2);
    readReg(6'h08, rd);
    check("R10 power-up rise event", rd, 8'h30);

    // R11: address decode and reserved bits
    rawCmp = 1'b0; waitCycles(5);
    writeReg(6'h08, 8'h10);
    readReg(6'h08, rd);
    check("R11 cleared", rd, 8'h00);
    writeReg(6'h09, 8'hFF);
    readReg(6'h08, rd);
    check("R11 foreign write ignored", rd, 8'h00);
    readReg(6'h09, rd);
    check("R11 foreign read zero", rd, 8'h00);
    writeReg(6'h08, 8'hFF);
    readReg(6'h08, rd);
    check("R11 reserved bits zero", rd, 8'h8B);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule